// File: doc/BRIEF.md
# Interrupt Status and Reset Controller

This block is the interrupt and reset front end of a camera-stream interface unit. It holds a parameterised number of interrupt banks, three by default. Each bank has a sticky status register, an enable mask and a pending-clear register, all 32 bits wide. Event pulses from the surrounding logic set status bits. Software stages clears per bank, and no clear takes effect until it writes a global commit command. A single level-high interrupt line is raised while any enabled status bit is set.

A write to the reset command register starts a fixed-length sub-unit reset sequence. During the sequence the written value is driven on the sub-unit reset lines. When the sequence finishes, a completion flag is raised in a fixed status bit, bit 27 of bank 0. Software observes this bit like any other event, either by polling or by enabling it in the mask. A typical software-reset sequence writes zero to every mask, writes all-ones to every clear register and then issues the commit.

Top module: `irq_rst_ctrl`

## Requirements
- R1: After synchronous reset, every register reads zero, and `irq_o`, `rst_busy_o` and `sub_rst_o` are low.
- R2: A high bit on `evt_i` sets the matching status bit on the next clock edge. The bit stays set until a commit clears it. Status reads return raw status, independent of the mask.
- R3: The mask register reads back the last value written. `irq_o` equals the OR over all banks of (status AND mask), registered one cycle after the status.
- R4: A write to a bank's clear register ORs the written value into that bank's pending bits, which read back from the same address. Status is unchanged until a commit.
- R5: A write of exactly 1 to the commit address (word 1) clears, in every bank, each status bit that has its pending bit set, and zeroes all pending bits. A write of any other value to that address changes neither status nor pending bits.
- R6: An event arriving in the same cycle as a commit that clears its bit leaves that status bit set.
- R7: A nonzero write to the reset command address (word 0) drives the written value on `sub_rst_o` and holds `rst_busy_o` high for exactly 16 cycles. Both then return to zero, and bit 27 of bank 0 is set whether or not it is masked.
- R8: A write to the reset command address while a sequence is running is ignored. A write of zero while idle starts nothing.
- R9: Mask, clear and commit effects of one bank never alter another bank's status or mask.
- R10: Reads return data on `bus_rdata` with `bus_rvalid` one cycle after `bus_rd`. The word map is: 0 reset command, 1 commit, 4b+4 status, 4b+5 mask and 4b+6 clear of bank b. Every other word, including words 0 and 1, reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| evt_i | input | NUM_BANKS*DATA_W (96) | Event pulses, bank b in bits [32b+31:32b] |
| irq_o | output | 1 | Level interrupt, registered |
| sub_rst_o | output | DATA_W (32) | Sub-unit reset lines during a sequence |
| rst_busy_o | output | 1 | Reset sequence in progress |

## Verification
The bench sweeps every bit of every bank with a single-bit event, and alternates between a mask that selects only that bit and a mask that selects every other bit. This separates the raw status path from the masked interrupt path and catches off-by-one bit routing. Each swept bit is staged for clearing, checked as still set, then committed and checked as cleared, while a neighbouring bank is read to prove it was not touched. Further patterns cover commit values other than 1, an event colliding with a commit, and the all-ones software-reset flush. Two reset runs cover the rest: one with the completion bit masked and one unmasked with a second command issued mid-run. Together they pin down the 16-cycle window, the ignored re-trigger and the one-cycle interrupt lag.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;
  // Field selector inside one bank's four-word page
  typedef enum logic [1:0] {
    FLD_STATUS = 2'd0,
    FLD_MASK   = 2'd1,
    FLD_CLEAR  = 2'd2,
    FLD_SPARE  = 2'd3
  } bank_fld_e;

  // Control words on page zero
  localparam logic [1:0] CTRL_RESET  = 2'd0;
  localparam logic [1:0] CTRL_COMMIT = 2'd1;

  // Only this exact value on the commit word applies staged clears
  localparam int unsigned COMMIT_KEY = 1;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] pend_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] drop;

  // Bits removed by this cycle's commit; fresh events override the drop
  assign drop = commit_i ? pend_o : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      mask_o   <= '0;
      pend_o   <= '0;
    end else begin
      status_o <= (status_o & ~drop) | evt_i;
      if (mask_we)
        mask_o <= wdata_i;
      if (commit_i)
        pend_o <= '0;
      else if (clr_we)
        pend_o <= pend_o | wdata_i;
    end
  end

  assign hit_o = |(status_o & mask_o);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R2

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R6

  AST_PEND_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (pend_o == '0)); // R5
endmodule

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] req_i,
  output logic [DATA_W-1:0] lines_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = start_i && !busy_o && (|req_i);
  assign done_o = busy_o && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      cnt     <= '0;
      lines_o <= '0;
    end else if (accept) begin
      busy_o  <= 1'b1;
      cnt     <= CNT_LAST;
      lines_o <= req_i;
    end else if (done_o) begin
      busy_o  <= 1'b0;
      lines_o <= '0;
    end else if (busy_o) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_LINES_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (lines_o == '0)); // R7

  AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> (busy_o && $stable(lines_o))); // R8
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NUM_BANKS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] hit_i,
  output logic                 irq_o
);
  always_ff @(posedge clk) begin
    if (rst)
      irq_o <= 1'b0;
    else
      irq_o <= |hit_i;
  end
endmodule

// File: rtl/irq_rst_ctrl.sv
module irq_rst_ctrl
  import irq_rst_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int RST_CYCLES = 16,
  parameter int DONE_BANK  = 0,
  parameter int DONE_BIT   = 27
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_rvalid,
  input  logic [NUM_BANKS*DATA_W-1:0] evt_i,
  output logic                        irq_o,
  output logic [DATA_W-1:0]           sub_rst_o,
  output logic                        rst_busy_o
);
  localparam int PAGE_W = ADDR_W - 2;

  logic [PAGE_W-1:0] page;
  bank_fld_e         fld;
  logic              commit;
  logic              rst_start;
  logic              rst_done;

  logic [DATA_W-1:0]    bank_status [NUM_BANKS];
  logic [DATA_W-1:0]    bank_mask   [NUM_BANKS];
  logic [DATA_W-1:0]    bank_pend   [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] bank_sel;

  assign page = bus_addr[ADDR_W-1:2];
  assign fld  = bank_fld_e'(bus_addr[1:0]);

  assign commit    = bus_wr && (page == '0) && (bus_addr[1:0] == CTRL_COMMIT)
                     && (bus_wdata == DATA_W'(COMMIT_KEY));
  assign rst_start = bus_wr && (page == '0) && (bus_addr[1:0] == CTRL_RESET);

  rst_seq #(
    .DATA_W    (DATA_W),
    .RST_CYCLES(RST_CYCLES)
  ) u_rst_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(rst_start),
    .req_i  (bus_wdata),
    .lines_o(sub_rst_o),
    .busy_o (rst_busy_o),
    .done_o (rst_done)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] evt_bank;

    assign bank_sel[b] = (page == PAGE_W'(b + 1));

    if (b == DONE_BANK) begin : g_done
      assign evt_bank = evt_i[b*DATA_W +: DATA_W]
                        | (DATA_W'(rst_done) << DONE_BIT);
    end else begin : g_plain
      assign evt_bank = evt_i[b*DATA_W +: DATA_W];
    end

    irq_bank #(
      .DATA_W(DATA_W)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .evt_i   (evt_bank),
      .mask_we (bus_wr && bank_sel[b] && (fld == FLD_MASK)),
      .clr_we  (bus_wr && bank_sel[b] && (fld == FLD_CLEAR)),
      .wdata_i (bus_wdata),
      .commit_i(commit),
      .status_o(bank_status[b]),
      .mask_o  (bank_mask[b]),
      .pend_o  (bank_pend[b]),
      .hit_o   (bank_hit[b])
    );
  end

  irq_merge #(
    .NUM_BANKS(NUM_BANKS)
  ) u_merge (
    .clk  (clk),
    .rst  (rst),
    .hit_i(bank_hit),
    .irq_o(irq_o)
  );

  // Read mux: control words and spare words return zero
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        unique case (fld)
          FLD_STATUS: rd_mux = bank_status[b];
          FLD_MASK:   rd_mux = bank_mask[b];
          FLD_CLEAR:  rd_mux = bank_pend[b];
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    rst_done |=> bank_status[DONE_BANK][DONE_BIT]); // R7

  AST_ONE_PAGE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_sel)); // R9
endmodule

// File: tb/test_irq_rst_ctrl.sv
module test_irq_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [NB*DW-1:0] evt = '0;
  logic          irq_o;
  logic [DW-1:0] sub_rst_o;
  logic          rst_busy_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 0;

  irq_rst_ctrl i_irq_rst_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_i(evt), .irq_o(irq_o),
    .sub_rst_o(sub_rst_o), .rst_busy_o(rst_busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] a_st(int b); return AW'(4*b + 4); endfunction
  function automatic logic [AW-1:0] a_mk(int b); return AW'(4*b + 5); endfunction
  function automatic logic [AW-1:0] a_cl(int b); return AW'(4*b + 6); endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 rvalid", DW'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic pulse_evt(int b, logic [DW-1:0] v);
    @(negedge clk);
    evt = '0;
    evt[b*DW +: DW] = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] rv;
    logic [DW-1:0] mk;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset state and full word sweep
    chk("R1 irq", DW'(irq_o), 32'd0);
    chk("R1 busy", DW'(rst_busy_o), 32'd0);
    chk("R1 lines", sub_rst_o, 32'd0);
    for (int a = 0; a < 32; a++) begin
      bus_read(AW'(a), rv);
      chk("R1 reg zero", rv, 32'd0);
    end

    // R3: mask readback per bank
    for (int b = 0; b < NB; b++) begin
      mk = 32'hA5A5_0000 ^ (32'h1111_1111 * (b + 1));
      bus_write(a_mk(b), mk);
      bus_read(a_mk(b), rv);
      chk("R3 mask readback", rv, mk);
    end

    // R2/R3/R4/R5/R9: every bit of every bank
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < DW; i++) begin
        mk = (i % 2 == 1) ? (32'd1 << i) : ~(32'd1 << i);
        bus_write(a_mk(b), mk);
        pulse_evt(b, 32'd1 << i);
        @(negedge clk);
        chk("R3 irq vs mask", DW'(irq_o), DW'(i % 2));
        bus_read(a_st(b), rv);
        chk("R2 raw status", rv, 32'd1 << i);
        bus_write(a_cl(b), 32'd1 << i);
        bus_read(a_cl(b), rv);
        chk("R4 pending readback", rv, 32'd1 << i);
        bus_read(a_st(b), rv);
        chk("R4 status held before commit", rv, 32'd1 << i);
        bus_write(AW'(1), 32'd1);
        bus_read(a_st(b), rv);
        chk("R5 status cleared", rv, 32'd0);
        bus_read(a_cl(b), rv);
        chk("R5 pending flushed", rv, 32'd0);
        chk("R3 irq low after clear", DW'(irq_o), 32'd0);
        bus_read(a_st((b + 1) % NB), rv);
        chk("R9 other bank untouched", rv, 32'd0);
      end
      bus_write(a_mk(b), 32'd0);
    end

    // R5: commit word with values other than 1 does nothing
    pulse_evt(2, 32'h0000_F00F);
    bus_write(a_cl(2), 32'h0000_000F);
    bus_write(AW'(1), 32'd2);
    bus_write(AW'(1), 32'hFFFF_FFFF);
    bus_read(a_st(2), rv);
    chk("R5 bad key keeps status", rv, 32'h0000_F00F);
    bus_read(a_cl(2), rv);
    chk("R5 bad key keeps pending", rv, 32'h0000_000F);
    bus_read(AW'(1), rv);
    chk("R10 commit word reads zero", rv, 32'd0);
    bus_write(AW'(1), 32'd1);
    bus_read(a_st(2), rv);
    chk("R5 partial clear", rv, 32'h0000_F000);

    // R6: event coincides with commit
    pulse_evt(1, 32'h0000_0028);
    bus_write(a_cl(1), 32'h0000_0028);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(1); bus_wdata = 32'd1;
    evt = '0; evt[1*DW +: DW] = 32'h0000_0008;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; evt = '0;
    bus_read(a_st(1), rv);
    chk("R6 collided bit kept", rv, 32'h0000_0008);
    bus_read(a_st(2), rv);
    chk("R9 bank2 same commit", rv, 32'h0000_F000);

    // Software-reset flush: masks zero, clear all, commit
    for (int b = 0; b < NB; b++) begin
      bus_write(a_mk(b), 32'd0);
      bus_write(a_cl(b), 32'hFFFF_FFFF);
    end
    bus_write(AW'(1), 32'd1);
    for (int b = 0; b < NB; b++) begin
      bus_read(a_st(b), rv);
      chk("R5 flush status", rv, 32'd0);
    end

    // R8: zero write starts nothing
    bus_write(AW'(0), 32'd0);
    chk("R8 zero write idle", DW'(rst_busy_o), 32'd0);

    // R7: masked completion, 16-cycle window
    bus_write(AW'(0), 32'hFE0F_1FFF);
    for (int k = 1; k <= 16; k++) begin
      chk("R7 busy window", DW'(rst_busy_o), 32'd1);
      chk("R7 lines", sub_rst_o, 32'hFE0F_1FFF);
      @(negedge clk);
    end
    chk("R7 busy ends", DW'(rst_busy_o), 32'd0);
    chk("R7 lines released", sub_rst_o, 32'd0);
    @(negedge clk);
    chk("R7 masked no irq", DW'(irq_o), 32'd0);
    bus_read(a_st(0), rv);
    chk("R7 done bit", rv, 32'h0800_0000);
    bus_write(a_cl(0), 32'h0800_0000);
    bus_write(AW'(1), 32'd1);

    // R7/R8: unmasked completion with a re-trigger mid-run
    bus_write(a_mk(0), 32'h0800_0000);
    bus_write(AW'(0), 32'h0000_00F0);
    for (int k = 1; k <= 16; k++) begin
      chk("R8 busy kept", DW'(rst_busy_o), 32'd1);
      chk("R8 lines kept", sub_rst_o, 32'h0000_00F0);
      if (k == 3) begin
        bus_wr = 1'b1; bus_addr = AW'(0); bus_wdata = 32'h0000_FFFF;
      end
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
    end
    chk("R8 run length unchanged", DW'(rst_busy_o), 32'd0);
    chk("R3 irq lags status", DW'(irq_o), 32'd0);
    @(negedge clk);
    chk("R7 unmasked irq", DW'(irq_o), 32'd1);
    bus_read(AW'(0), rv);
    chk("R10 reset word reads zero", rv, 32'd0);

    finish_run();
  end
endmodule